// File: doc/BRIEF.md
# Clock Gating Control Unit

This block switches three clock domains on and off from one control register: a memory controller clock, a bus clock and a peripheral clock. Software writes the register over a simple write port and reads it back combinationally. Each domain gets an enable output and a gated clock. The gated clock comes from a cell that samples the enable while its source clock is low and ANDs the sampled value with the source, so a change never produces a short pulse.

The bus clock is handled differently from the other two. It always runs while the processor core executes. Its register bit matters only when the core reports HALT. That HALT input is first synchronised into the bus clock domain. The register itself runs on the ungated bus clock, so software can re-enable a stopped domain at any time. The memory clock source may run at twice the bus frequency, and the same register bit gates it.

Top module: `clock_gate_unit`

## Requirements
- R1: Register bit 4 enables the memory controller clock. With the bit at 1, `memEnOut` is 1 and `memClkG` follows `memClk`. With the bit at 0, both are held low.
- R2: Register bit 2 enables the peripheral clock. With the bit at 1, `perEnOut` is 1 and `perClkG` follows `perClk`. With the bit at 0, both are held low.
- R3: While `haltIn` is 0, `busEnOut` is 1 and `busClkG` follows `busClk`, whatever value bit 3 holds.
- R4: While `haltIn` is 1, the bus clock stops only if bit 3 is 0. Suppose `haltIn` rises before rising edge E of `busClk`, and bit 3 is 0. Then the `busClkG` pulses at E and E+1 still occur, and the pulse at E+2 is the first one suppressed.
- R5: `rdData` returns bits 4, 3 and 2 of the register. Every other bit reads as 0, and writes to those other bits have no effect.
- R6: After reset, all three enables are 1, all three gated clocks run, and `rdData` reads 0x1C.
- R7: A write sampled at rising edge E of `busClk` leaves the gated pulse at E whole. The change first affects the pulse at E+1.
- R8: If `memClk` runs at twice the bus frequency, both of its pulses in each bus period pass while bit 4 is 1. Neither passes while bit 4 is 0.
- R9: Register writes still take effect while the bus clock is stopped. Writing bit 3 back to 1 restarts `busClkG`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| busClk | input | 1 | Ungated bus clock source; clocks the register and the HALT synchroniser |
| memClk | input | 1 | Memory controller clock source (1x or 2x bus frequency) |
| perClk | input | 1 | Peripheral clock source |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | DATA_W | Register write data |
| rdData | output | DATA_W | Register readback |
| haltIn | input | 1 | Core HALT indication (asynchronous) |
| memEnOut | output | 1 | Memory domain enable |
| busEnOut | output | 1 | Bus domain enable |
| perEnOut | output | 1 | Peripheral domain enable |
| memClkG | output | 1 | Gated memory controller clock |
| busClkG | output | 1 | Gated bus clock |
| perClkG | output | 1 | Gated peripheral clock |

## Verification
The results fall due at different times. Readback and the enable outputs change at the write edge itself. A gated clock first changes one source edge after the write edge. A HALT change reaches the bus clock only at the third rising edge, because of the two synchroniser flops and the low-phase latch. The table tests let several cycles settle before sampling. The directed latency tests sample at each edge, 1.6 ns after the rising edge, while every source clock is high. They confirm that the pulse at the write edge is intact and that the pulse at exactly the predicted later edge is gone.

// File: rtl/cgu_pkg.sv
`timescale 1ns/1ps
package cgu_pkg;
  localparam int NUM_DOMAINS = 3;
  localparam int DOM_MEM = 2;
  localparam int DOM_BUS = 1;
  localparam int DOM_PER = 0;

  typedef struct packed {
    logic memRun;
    logic busRun;
    logic perRun;
  } gateStrobes_t;
endpackage

// File: rtl/cgu_ctrl.sv
`timescale 1ns/1ps
module cgu_ctrl
  import cgu_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int MEM_BIT     = 4,
  parameter int BUS_BIT     = 3,
  parameter int PER_BIT     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              busClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              haltIn,
  output logic [DATA_W-1:0] rdData,
  output gateStrobes_t      strobes
);
  localparam logic [DATA_W-1:0] KEEP_MASK =
    (DATA_W'(1) << MEM_BIT) | (DATA_W'(1) << BUS_BIT) | (DATA_W'(1) << PER_BIT);

  logic [DATA_W-1:0]      ctrlReg;
  logic [SYNC_STAGES-1:0] haltPipe;
  logic                   haltSync;

  // Control register: only the three enable bits are stored; reset enables all.
  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN)     ctrlReg <= KEEP_MASK;
    else if (wrEn) ctrlReg <= wrData & KEEP_MASK;
  end

  // HALT synchroniser into the bus domain.
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge busClk or negedge rstN) begin
        if (!rstN) haltPipe <= '0;
        else       haltPipe <= haltIn;
      end
    end else begin : g_syncN
      always_ff @(posedge busClk or negedge rstN) begin
        if (!rstN) haltPipe <= '0;
        else       haltPipe <= {haltPipe[SYNC_STAGES-2:0], haltIn};
      end
    end
  endgenerate

  assign haltSync = haltPipe[SYNC_STAGES-1];
  assign rdData   = ctrlReg;

  always_comb begin
    strobes.memRun = ctrlReg[MEM_BIT];
    strobes.perRun = ctrlReg[PER_BIT];
    // Bus clock may only stop while the core is halted.
    strobes.busRun = !haltSync || ctrlReg[BUS_BIT];
  end
endmodule

// File: rtl/cgu_gate_cell.sv
`timescale 1ns/1ps
module cgu_gate_cell (
  input  logic clkIn,
  input  logic enIn,
  output logic clkOut
);
  logic enLatched;

  // Transparent while the source is low; holds through the high phase.
  always_latch begin
    if (!clkIn) enLatched <= enIn;
  end

  assign clkOut = clkIn & enLatched;
endmodule

// File: rtl/cgu_datapath.sv
`timescale 1ns/1ps
module cgu_datapath
  import cgu_pkg::*;
(
  input  logic         memClk,
  input  logic         busClk,
  input  logic         perClk,
  input  gateStrobes_t strobes,
  output logic         memEnOut,
  output logic         busEnOut,
  output logic         perEnOut,
  output logic         memClkG,
  output logic         busClkG,
  output logic         perClkG
);
  logic [NUM_DOMAINS-1:0] srcClk;
  logic [NUM_DOMAINS-1:0] enVec;
  logic [NUM_DOMAINS-1:0] gatedClk;

  assign srcClk[DOM_MEM] = memClk;
  assign srcClk[DOM_BUS] = busClk;
  assign srcClk[DOM_PER] = perClk;
  assign enVec           = strobes;

  generate
    for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
      cgu_gate_cell u_cell (
        .clkIn  (srcClk[d]),
        .enIn   (enVec[d]),
        .clkOut (gatedClk[d])
      );
    end
  endgenerate

  assign memEnOut = enVec[DOM_MEM];
  assign busEnOut = enVec[DOM_BUS];
  assign perEnOut = enVec[DOM_PER];
  assign memClkG  = gatedClk[DOM_MEM];
  assign busClkG  = gatedClk[DOM_BUS];
  assign perClkG  = gatedClk[DOM_PER];
endmodule

// File: rtl/clock_gate_unit.sv
`timescale 1ns/1ps
module clock_gate_unit
  import cgu_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int MEM_BIT     = 4,
  parameter int BUS_BIT     = 3,
  parameter int PER_BIT     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              busClk,
  input  logic              memClk,
  input  logic              perClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              haltIn,
  output logic              memEnOut,
  output logic              busEnOut,
  output logic              perEnOut,
  output logic              memClkG,
  output logic              busClkG,
  output logic              perClkG
);
  gateStrobes_t strobes;

  cgu_ctrl #(
    .DATA_W(DATA_W), .MEM_BIT(MEM_BIT), .BUS_BIT(BUS_BIT),
    .PER_BIT(PER_BIT), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .busClk (busClk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrData (wrData),
    .haltIn (haltIn),
    .rdData (rdData),
    .strobes(strobes)
  );

  cgu_datapath u_dp (
    .memClk  (memClk),
    .busClk  (busClk),
    .perClk  (perClk),
    .strobes (strobes),
    .memEnOut(memEnOut),
    .busEnOut(busEnOut),
    .perEnOut(perEnOut),
    .memClkG (memClkG),
    .busClkG (busClkG),
    .perClkG (perClkG)
  );
endmodule

// File: rtl/cgu_checker.sv
`timescale 1ns/1ps
module cgu_checker #(
  parameter int DATA_W      = 8,
  parameter int MEM_BIT     = 4,
  parameter int BUS_BIT     = 3,
  parameter int PER_BIT     = 2,
  parameter int SYNC_STAGES = 2
) (
  input logic              busClk,
  input logic              rstN,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              haltIn,
  input logic              memEnOut,
  input logic              busEnOut,
  input logic              perEnOut
);
  localparam logic [DATA_W-1:0] KEEP_MASK =
    (DATA_W'(1) << MEM_BIT) | (DATA_W'(1) << BUS_BIT) | (DATA_W'(1) << PER_BIT);
  localparam int CNT_W = $clog2(SYNC_STAGES + 2);

  // Number of consecutive bus edges with HALT low, saturating.
  logic [CNT_W-1:0] runCnt;
  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN)                       runCnt <= CNT_W'(SYNC_STAGES);
    else if (haltIn)                 runCnt <= '0;
    else if (runCnt < CNT_W'(SYNC_STAGES)) runCnt <= runCnt + 1'b1;
  end

  p_mem_write_r1: assert property (@(posedge busClk) disable iff (!rstN)
    wrEn |=> (memEnOut == $past(wrData[MEM_BIT])));

  p_per_write_r2: assert property (@(posedge busClk) disable iff (!rstN)
    wrEn |=> (perEnOut == $past(wrData[PER_BIT])));

  p_bus_run_normal_r3: assert property (@(posedge busClk) disable iff (!rstN)
    (runCnt >= CNT_W'(SYNC_STAGES)) |-> busEnOut);

  p_bus_stop_needs_bit_r4: assert property (@(posedge busClk) disable iff (!rstN)
    !busEnOut |-> !rdData[BUS_BIT]);

  p_unused_zero_r5: assert property (@(posedge busClk) disable iff (!rstN)
    (rdData & ~KEEP_MASK) == '0);
endmodule

bind clock_gate_unit cgu_checker #(
  .DATA_W(DATA_W), .MEM_BIT(MEM_BIT), .BUS_BIT(BUS_BIT),
  .PER_BIT(PER_BIT), .SYNC_STAGES(SYNC_STAGES)
) u_cgu_checker (
  .busClk  (busClk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .wrData  (wrData),
  .rdData  (rdData),
  .haltIn  (haltIn),
  .memEnOut(memEnOut),
  .busEnOut(busEnOut),
  .perEnOut(perEnOut)
);

// File: tb/clock_gate_unit_bench.sv
`timescale 1ns/1ps
module clock_gate_unit_bench;
  logic       busClk = 1'b0;
  logic       memClk = 1'b0;
  logic       rstN   = 1'b0;
  logic       wrEn   = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       haltIn = 1'b0;
  logic [7:0] rdData;
  logic       memEnOut, busEnOut, perEnOut;
  logic       memClkG, busClkG, perClkG;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 1'b0;

  always #2.5  busClk = ~busClk;   // 200 MHz
  always #1.25 memClk = ~memClk;   // 2x, double-frequency memory clock

  clock_gate_unit u_clock_gate_unit (
    .busClk(busClk), .memClk(memClk), .perClk(busClk), .rstN(rstN),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .haltIn(haltIn),
    .memEnOut(memEnOut), .busEnOut(busEnOut), .perEnOut(perEnOut),
    .memClkG(memClkG), .busClkG(busClkG), .perClkG(perClkG)
  );

  typedef struct packed {
    logic [7:0] wr;
    logic       halt;
    logic [7:0] rd;
    logic       m;
    logic       b;
    logic       p;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{8'h1C, 1'b0, 8'h1C, 1'b1, 1'b1, 1'b1},
    '{8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0},
    '{8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0},
    '{8'h08, 1'b1, 8'h08, 1'b0, 1'b1, 1'b0},
    '{8'hFF, 1'b1, 8'h1C, 1'b1, 1'b1, 1'b1},
    '{8'hE3, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0},
    '{8'h10, 1'b1, 8'h10, 1'b1, 1'b0, 1'b0},
    '{8'h04, 1'b0, 8'h04, 1'b0, 1'b1, 1'b1}
  };

  task automatic check(input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
    testCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  // Advance to 1.6 ns after a bus rising edge: all source clocks high.
  task automatic tick();
    @(posedge busClk);
    #1.6;
  endtask

  task automatic regWrite(input logic [7:0] d);
    @(negedge busClk);
    wrEn   = 1'b1;
    wrData = d;
    @(negedge busClk);
    wrEn   = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge busClk);
    rstN = 1'b1;
    tick();
    // R6: reset state
    check("R6", "rdData", rdData, 8'h1C);
    check("R6", "enables", {5'b0, memEnOut, busEnOut, perEnOut}, 8'h07);
    check("R6", "gated clocks", {5'b0, memClkG, busClkG, perClkG}, 8'h07);

    // Table walk
    foreach (VEC[i]) begin
      @(negedge busClk);
      haltIn = VEC[i].halt;
      regWrite(VEC[i].wr);
      repeat (4) tick();
      check("R5", $sformatf("v%0d rdData", i), rdData, VEC[i].rd);
      check("R1", $sformatf("v%0d memEnOut", i), {7'b0, memEnOut}, {7'b0, VEC[i].m});
      check("R1", $sformatf("v%0d memClkG", i), {7'b0, memClkG}, {7'b0, VEC[i].m});
      check(VEC[i].halt ? "R4" : "R3", $sformatf("v%0d busEnOut", i),
            {7'b0, busEnOut}, {7'b0, VEC[i].b});
      check(VEC[i].halt ? "R4" : "R3", $sformatf("v%0d busClkG", i),
            {7'b0, busClkG}, {7'b0, VEC[i].b});
      check("R2", $sformatf("v%0d perEnOut", i), {7'b0, perEnOut}, {7'b0, VEC[i].p});
      check("R2", $sformatf("v%0d perClkG", i), {7'b0, perClkG}, {7'b0, VEC[i].p});
      #2.5; // second memClk pulse in this bus period
      check("R8", $sformatf("v%0d memClkG 2nd pulse", i), {7'b0, memClkG}, {7'b0, VEC[i].m});
    end

    // R7: write at edge E keeps pulse at E, stops pulse at E+1
    @(negedge busClk);
    haltIn = 1'b0;
    regWrite(8'h1C);
    repeat (2) tick();
    @(negedge busClk);
    wrEn = 1'b1; wrData = 8'h18;
    tick();
    wrEn = 1'b0;
    check("R7", "perClkG at write edge", {7'b0, perClkG}, 8'h01);
    check("R7", "perEnOut after write", {7'b0, perEnOut}, 8'h00);
    tick();
    check("R7", "perClkG next edge", {7'b0, perClkG}, 8'h00);

    // R4: HALT latency with bit 3 = 0
    regWrite(8'h14);
    repeat (3) tick();
    check("R3", "busClkG running before halt", {7'b0, busClkG}, 8'h01);
    @(negedge busClk);
    haltIn = 1'b1;
    tick();
    check("R4", "busClkG at E", {7'b0, busClkG}, 8'h01);
    tick();
    check("R4", "busClkG at E+1", {7'b0, busClkG}, 8'h01);
    tick();
    check("R4", "busClkG at E+2", {7'b0, busClkG}, 8'h00);

    // R9: write while bus clock stopped
    regWrite(8'h1C);
    repeat (3) tick();
    check("R9", "rdData while halted", rdData, 8'h1C);
    check("R9", "busClkG restarted", {7'b0, busClkG}, 8'h01);

    // R6: reset again restores defaults
    regWrite(8'h00);
    @(negedge busClk);
    rstN = 1'b0;
    haltIn = 1'b0;
    @(negedge busClk);
    rstN = 1'b1;
    repeat (2) tick();
    check("R6", "rdData after re-reset", rdData, 8'h1C);
    check("R6", "gated clocks after re-reset",
          {5'b0, memClkG, busClkG, perClkG}, 8'h07);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule